// File: doc/BRIEF.md
# Page-Wrapping Word Address Pointer

This block keeps the word address for a byte-wide serial memory built as 256 pages of 32 bytes. The address is 12 or 13 bits wide, set by a parameter. A controller loads the pointer from the two address bytes it received off the bus. It then sends one step strobe after each data byte that moves, together with a mode bit that says whether that byte was read or written.

The two modes wrap in different ways. A write step changes only the byte-in-page field, so a burst that runs past the end of a page starts again at the first byte of the same page. A read step advances the whole address and rolls over from the top of the array to zero. The pointer keeps its value between transfers, so a new read with no address phase carries on from the byte after the last one accessed.

On each load the block also latches the base address of the page that was loaded, for use by a page write buffer. It flags whether the current address lies in the top quarter of the array, which the storage side uses to block writes there.

Top module: `page_wrap_addr_ptr`

## Requirements
- R1: While and right after reset, `addr_o`, `page_base_o` and `prot_o` are all zero.
- R2: A load makes `addr_o` equal `{addr_hi_i[ADDR_W-9:0], addr_lo_i}` on the clock edge after the load. The unused top bits of `addr_hi_i` (bits 7 down to ADDR_W-8) have no effect on any output.
- R3: When `load_i` and `step_i` are both high in the same cycle, the load wins and the step is dropped.
- R4: A step with `step_rd_i`=0 (write) adds one to bits [4:0] modulo 32 and leaves bits [ADDR_W-1:5] unchanged, so 31 in the page is followed by 0 in the same page.
- R5: A step with `step_rd_i`=1 (read) adds one to the full address modulo 2^ADDR_W, so the all-ones address is followed by zero.
- R6: In a cycle with neither load nor step, the address stays unchanged for any number of cycles.
- R7: `page_base_o` takes the loaded address with bits [4:0] cleared, and changes only on a load. Steps never change it.
- R8: `prot_o` is 1 exactly when the two top bits of `addr_o` are both 1, which marks the upper quarter of the array. It follows `addr_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load the pointer from the two address bytes |
| addr_hi_i | input | 8 | High address byte; only the low ADDR_W-8 bits are used |
| addr_lo_i | input | 8 | Low address byte |
| step_i | input | 1 | Advance the pointer after one data byte |
| step_rd_i | input | 1 | Step mode: 1 = read (full wrap), 0 = write (wrap inside the page) |
| addr_o | output | ADDR_W | Current word address |
| page_base_o | output | ADDR_W | Latched base address of the loaded page |
| prot_o | output | 1 | Current address lies in the protected upper quarter |

## Verification
The hardest cases to reach are the two wrap points. Each one needs the pointer to sit on a specific boundary value: the last byte of a page for a write step, and the all-ones address for a read step. The stimulus gets there by loading an address one or two bytes below each boundary and then stepping across it. It also loads through a high byte with its ignored bits set, and crosses from 0x17FF into the protected quarter with a read step. Load and step are raised together in one cycle to show which one wins.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PAGE_BITS = 5;  // 32 bytes per page

  typedef enum logic {
    STEP_WRITE = 1'b0,
    STEP_READ  = 1'b1
  } step_mode_e;
endpackage

// File: rtl/ptr_next.sv
module ptr_next
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  step_mode_e        mode_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam int unsigned ROW_W = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0]    nxt_rd;
  logic [PAGE_BITS-1:0] col_inc;

  assign nxt_rd  = cur_i + ADDR_W'(1);
  assign col_inc = cur_i[PAGE_BITS-1:0] + PAGE_BITS'(1);

  always_comb begin
    if (mode_i == STEP_READ) nxt_o = nxt_rd;
    else                     nxt_o = {cur_i[ADDR_W-1 -: ROW_W], col_inc};
  end
endmodule

// File: rtl/prot_decode.sv
module prot_decode #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  // upper quarter: both top bits set
  assign prot_o = &addr_i[ADDR_W-1 -: 2];
endmodule

// File: rtl/page_wrap_addr_ptr.sv
module page_wrap_addr_ptr
  import ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        addr_hi_i,
  input  logic [7:0]        addr_lo_i,
  input  logic              step_i,
  input  logic              step_rd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] page_base_o,
  output logic              prot_o
);
  localparam int unsigned HI_USED = ADDR_W - BYTE_W;
  localparam logic [ADDR_W-1:0] COL_MASK = ADDR_W'((1 << PAGE_BITS) - 1);

  logic [ADDR_W-1:0] addr_q, base_q, load_val, step_val;
  logic              unused_hi;

  assign load_val  = {addr_hi_i[HI_USED-1:0], addr_lo_i};
  assign unused_hi = ^addr_hi_i[7:HI_USED];

  ptr_next #(.ADDR_W(ADDR_W)) u_next (
    .cur_i  (addr_q),
    .mode_i (step_rd_i ? STEP_READ : STEP_WRITE),
    .nxt_o  (step_val)
  );

  prot_decode #(.ADDR_W(ADDR_W)) u_prot (
    .addr_i (addr_q),
    .prot_o (prot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      base_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val;
      base_q <= load_val & ~COL_MASK;
    end else if (step_i) begin
      addr_q <= step_val;
    end
  end

  assign addr_o      = addr_q;
  assign page_base_o = base_q;

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past({addr_hi_i[HI_USED-1:0], addr_lo_i}));

  a_r4_write_row_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !step_rd_i && !load_i) |=>
      addr_o[ADDR_W-1:PAGE_BITS] == $past(addr_o[ADDR_W-1:PAGE_BITS]));

  a_r5_read_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && step_rd_i && !load_i) |=> addr_o == ADDR_W'($past(addr_o) + 1));

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_o));

  a_r7_base_only_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(page_base_o));
endmodule

// File: tb/page_wrap_addr_ptr_tb_top.sv
`timescale 1ns/1ps
module page_wrap_addr_ptr_tb_top;
  localparam int unsigned AW = 13;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          load = 0, step = 0, step_rd = 0;
  logic [7:0]    hi = 0, lo = 0;
  logic [AW-1:0] addr, base;
  logic          prot;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  page_wrap_addr_ptr #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .addr_hi_i(hi), .addr_lo_i(lo),
    .step_i(step), .step_rd_i(step_rd), .addr_o(addr), .page_base_o(base), .prot_o(prot)
  );

  // reference model state
  logic [AW-1:0] m_addr = 0, m_base = 0;
  logic [2*AW:0] exp_q[$];
  string         tag_q[$];

  function automatic logic m_prot(logic [AW-1:0] a);
    return a >= AW'(3 << (AW - 2));
  endfunction

  task automatic chk(string tag, logic [2*AW:0] act, logic [2*AW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr/base/prot act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, bit ld, logic [7:0] h, logic [7:0] l, bit st, bit rd);
    @(negedge clk);
    load = ld; hi = h; lo = l; step = st; step_rd = rd;
    if (ld) begin
      m_addr = {h[AW-9:0], l};
      m_base = m_addr & ~AW'(31);
    end else if (st) begin
      if (rd) m_addr = m_addr + AW'(1);
      else    m_addr = {m_addr[AW-1:5], 5'(m_addr[4:0] + 5'd1)};
    end
    exp_q.push_back({m_addr, m_base, m_prot(m_addr)});
    tag_q.push_back(tag);
    @(posedge clk);
    #2;
    load = 0; step = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2*AW:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {addr, base, prot}, e);
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #23;
    chk("R1", {addr, base, prot}, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {addr, base, prot}, '0);
    // R2 basic load
    op("R2", 1, 8'h12, 8'h34, 0, 0);
    // R4 write wrap inside page
    op("R2", 1, 8'h12, 8'h3E, 0, 0);
    op("R4", 0, 8'h00, 8'h00, 1, 0);
    op("R4", 0, 8'h00, 8'h00, 1, 0);
    op("R4", 0, 8'h00, 8'h00, 1, 0);
    // R5 read crosses page
    op("R2", 1, 8'h12, 8'h3F, 0, 0);
    op("R5", 0, 8'h00, 8'h00, 1, 1);
    op("R7", 0, 8'h00, 8'h00, 1, 1);
    // R2 ignored top bits, R8 protected, R5 full wrap
    op("R2", 1, 8'hFF, 8'hFE, 0, 0);
    op("R5", 0, 8'h00, 8'h00, 1, 1);
    op("R5", 0, 8'h00, 8'h00, 1, 1);
    // R3 load beats step
    op("R3", 1, 8'h0A, 8'h5F, 1, 1);
    op("R3", 1, 8'h0B, 8'h1F, 1, 0);
    // R6 hold over idle cycles
    op("R6", 0, 8'hFF, 8'hFF, 0, 1);
    op("R6", 0, 8'h55, 8'hAA, 0, 0);
    op("R6", 0, 8'h00, 8'h00, 0, 1);
    // R8 boundary into upper quarter
    op("R8", 1, 8'h17, 8'hFF, 0, 0);
    op("R8", 0, 8'h00, 8'h00, 1, 1);
    op("R4", 0, 8'h00, 8'h00, 1, 0);
    // R2 ignored top bits compare with clean byte
    op("R2", 1, 8'hE0, 8'h00, 0, 0);
    op("R2", 1, 8'h1F, 8'hE0, 0, 0);
    op("R8", 0, 8'h00, 8'h00, 1, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule